// File: doc/BRIEF.md
# Configuration Image Programmer with Read-Back Verify

This block writes an eleven-byte configuration image into a byte-wide non-volatile memory and checks each byte after writing it. Eight of the bytes are fixed: four identifier bytes and four address-prefix bytes. Two bytes carry a 16-bit serial number that is captured when the run starts. The last byte is a checksum over the other ten. The bytes go out one at a time in ascending address order through a simple request/acknowledge port. A separate engine performs the real memory cycles.

For each byte the sequencer runs a loop. It writes the byte, stays idle for a programmable settle time, reads the byte back and compares it with the expected value. On a mismatch it writes the byte again, up to a limit on the number of attempts. When all eleven bytes compare equal, the six bytes at image addresses 4 to 9 are copied into a station-address register, so the address is in use at once without a reload from memory. A one-cycle `done` pulse then marks success. If any byte runs out of attempts, the run stops with a one-cycle `fail` pulse and a code equal to the failing address plus one.

The state machine has ten states:
- S_IDLE waits for `start`.
- S_ARM presets the verify register for the current byte.
- S_CHECK compares.
- S_WRITE issues a write and holds it until acknowledged.
- S_SETTLE waits.
- S_READ issues a read and holds it until acknowledged.
- S_ADVANCE moves to the next address.
- S_PUBLISH loads the station register.
- S_DONE and S_FAIL each last one cycle.

The transitions are:
- S_IDLE→S_ARM on start.
- S_ARM→S_CHECK.
- S_CHECK→S_ADVANCE on match.
- S_CHECK→S_WRITE on mismatch with attempts left.
- S_CHECK→S_FAIL on mismatch with none left.
- S_WRITE→S_SETTLE on ack.
- S_SETTLE→S_READ when the timer expires.
- S_READ→S_CHECK on ack.
- S_ADVANCE→S_ARM for the next byte.
- S_ADVANCE→S_PUBLISH after byte 10.
- S_PUBLISH→S_DONE.
- S_DONE→S_IDLE.
- S_FAIL→S_IDLE.

Top module: `cfg_image_prog`

## Requirements
- R1: Image addresses 0 to 7 receive the constants 0x4E, 0x57, 0x59, 0x46, 0x00, 0x10, 0x57, 0xC0, in that address order.
- R2: Address 8 receives serial[15:8] and address 9 receives serial[7:0], using the serial value sampled on the clock edge that accepts `start`.
- R3: Address 10 receives (256 − ((0x55 + sum of bytes 0..9) mod 256)) mod 256.
- R4: Addresses are programmed in ascending order 0 to 10. A write has `mem_we`=1 and a read has `mem_we`=0. Each request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is seen.
- R5: Every byte is written at least once, even when the memory already holds the expected value.
- R6: After each write acknowledge, `mem_req` stays low for exactly SETTLE_CYCLES cycles. A read of the same address follows.
- R7: A read-back that differs from the expected byte causes another write of that byte. A byte is written at most MAX_TRIES times.
- R8: When a byte still mismatches after MAX_TRIES writes, `fail` pulses and `fail_code` equals that address plus one. No further memory request is made, and `sta_addr` keeps its previous value.
- R9: After all eleven bytes verify, `sta_addr` holds image bytes 4..9, with byte 4 in bits [47:40] and byte 9 in bits [7:0]. It holds this value while `done` pulses.
- R10: `done` and `fail` are single-cycle pulses, never high together. `busy` is high from the cycle after `start` is accepted through the pulse cycle.
- R11: A `start` while `busy` is high has no effect on the running sequence or its serial number.
- R12: After reset, `busy`, `done`, `fail`, `mem_req` are 0 and `sta_addr` and `fail_code` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (accepted only when idle) |
| serial | input | 16 | Serial number placed at image addresses 8 and 9 |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 8 | Byte address of the access |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | One-cycle completion of the pending access |
| mem_rdata | input | 8 | Read data, valid with mem_ack on a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: all bytes verified, station address loaded |
| fail | output | 1 | One-cycle pulse: a byte ran out of attempts |
| fail_code | output | 8 | Failing address plus one, valid with fail and held afterwards |
| sta_addr | output | 48 | Station address register, loaded on success |

## Verification
`busy` rises one cycle after the edge that accepts `start`. A read request is due exactly SETTLE_CYCLES cycles after the edge that takes a write acknowledge. The memory model in the bench answers every request on the falling edge, so each acknowledge reaches the block on the next rising edge. `sta_addr` is loaded one cycle before `done`, and `fail_code` is valid in the same cycle as `fail`. The bench therefore checks the station value and the failure code in the falling-edge sample where the pulse is seen. It also counts idle cycles between each write and the read that follows, to confirm the settle length is exact.

// File: rtl/cfg_prog_pkg.sv
package cfg_prog_pkg;

    localparam int IMG_LEN  = 11;
    localparam int IDX_W    = 4;
    localparam int STA_LEN  = 6;
    localparam int STA_BASE = 4;
    localparam int SUM_LEN  = IMG_LEN - 1;

    typedef logic [7:0] byte_t;

    localparam byte_t CHK_SEED = 8'h55;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM,
        S_CHECK,
        S_WRITE,
        S_SETTLE,
        S_READ,
        S_ADVANCE,
        S_PUBLISH,
        S_DONE,
        S_FAIL
    } prog_state_t;

    // Fixed image content, addresses 0..7
    function automatic byte_t fixed_byte(input int unsigned pos);
        byte_t v;
        unique case (pos)
            0:       v = 8'h4E;
            1:       v = 8'h57;
            2:       v = 8'h59;
            3:       v = 8'h46;
            4:       v = 8'h00;
            5:       v = 8'h10;
            6:       v = 8'h57;
            7:       v = 8'hC0;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfg_image_build.sv
module cfg_image_build
    import cfg_prog_pkg::*;
(
    input  logic [15:0]        serial,
    input  logic [IDX_W-1:0]   idx,
    output byte_t              cur_byte,
    output logic [8*STA_LEN-1:0] sta_image
);

    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0][7:0] img;
    byte_t                 acc;

    always_comb begin
        img = '0;
        for (int i = 0; i < 8; i++) begin
            img[i] = fixed_byte(i);
        end
        img[8] = serial[15:8];
        img[9] = serial[7:0];
        acc = CHK_SEED;
        for (int i = 0; i < SUM_LEN; i++) begin
            acc = acc + img[i];
        end
        img[SUM_LEN] = 8'h00 - acc;
    end

    assign cur_byte = img[idx];

    genvar g;
    generate
        for (g = 0; g < STA_LEN; g++) begin : g_sta
            assign sta_image[8*(STA_LEN-g)-1 -: 8] = img[STA_BASE+g];
        end
    endgenerate

endmodule

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
    parameter int CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    // R6
    settle_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R6
    settle_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/cfg_station_bank.sv
module cfg_station_bank #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

    // R8
    station_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));

endmodule

// File: rtl/cfg_image_prog.sv
module cfg_image_prog
    import cfg_prog_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1_000_000,
    parameter int MAX_TRIES     = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] serial,
    output logic        mem_req,
    output logic        mem_we,
    output logic [7:0]  mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic        mem_ack,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        fail,
    output logic [7:0]  fail_code,
    output logic [47:0] sta_addr
);

    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] TRY_LIMIT = TRY_W'(MAX_TRIES);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(IMG_LEN - 1);

    prog_state_t        state, nxt;
    logic [IDX_W-1:0]   idx;
    logic [TRY_W-1:0]   tries;
    byte_t              verify;
    logic [15:0]        serial_q;
    byte_t              cur_byte;
    logic [47:0]        sta_image;
    logic               settle_done;
    logic               sta_load;

    cfg_image_build u_img (
        .serial    (serial_q),
        .idx       (idx),
        .cur_byte  (cur_byte),
        .sta_image (sta_image)
    );

    cfg_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_SETTLE),
        .expired (settle_done)
    );

    cfg_station_bank #(.WIDTH(48)) u_sta (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sta_load),
        .din   (sta_image),
        .dout  (sta_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = S_ARM;
            S_ARM:     nxt = S_CHECK;
            S_CHECK: begin
                if (verify == cur_byte)      nxt = S_ADVANCE;
                else if (tries == TRY_LIMIT) nxt = S_FAIL;
                else                         nxt = S_WRITE;
            end
            S_WRITE:   if (mem_ack) nxt = S_SETTLE;
            S_SETTLE:  if (settle_done) nxt = S_READ;
            S_READ:    if (mem_ack) nxt = S_CHECK;
            S_ADVANCE: nxt = (idx == LAST_IDX) ? S_PUBLISH : S_ARM;
            S_PUBLISH: nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            S_FAIL:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            tries     <= '0;
            verify    <= '0;
            serial_q  <= '0;
            fail_code <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        serial_q <= serial;
                        idx      <= '0;
                    end
                end
                S_ARM: begin
                    tries  <= '0;
                    verify <= ~cur_byte;
                end
                S_CHECK: begin
                    if (verify != cur_byte && tries == TRY_LIMIT)
                        fail_code <= 8'(idx) + 8'd1;
                end
                S_WRITE:   if (mem_ack) tries <= tries + 1'b1;
                S_READ:    if (mem_ack) verify <= mem_rdata;
                S_ADVANCE: if (idx != LAST_IDX) idx <= idx + 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = (state == S_WRITE) || (state == S_READ);
        mem_we    = (state == S_WRITE);
        mem_addr  = 8'(idx);
        mem_wdata = cur_byte;
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        fail      = (state == S_FAIL);
        sta_load  = (state == S_PUBLISH);
    end

    // R10
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R4
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr < 8'(IMG_LEN));

    // R8
    fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !mem_req);

    // R8
    fail_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (fail_code >= 8'd1 && fail_code <= 8'(IMG_LEN)));

    // R6
    write_then_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> !mem_req);

    // R11
    serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(serial_q));

endmodule

// File: tb/tb_cfg_image_prog.sv
module tb_cfg_image_prog;

    localparam int SETTLE = 16;
    localparam int TRIES  = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] serial = 16'h0000;
    logic        mem_req, mem_we, mem_ack;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, fail;
    logic [7:0]  fail_code;
    logic [47:0] sta_addr;

    always #10 clk = ~clk;

    cfg_image_prog #(.SETTLE_CYCLES(SETTLE), .MAX_TRIES(TRIES)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .serial(serial),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail), .fail_code(fail_code),
        .sta_addr(sta_addr)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Memory model and monitors (answer on falling edge)
    logic [7:0] mem [16];
    int  wr_cnt [16];
    int  total_req;
    int  order_err, gap_err, done_cyc, fail_cyc;
    int  last_addr, gap;
    bit  await_rd;
    int  wr_addr;
    int  bad_addr = -1;
    int  bad_left = 0;
    bit  clr = 1'b0;

    initial begin
        mem_ack = 1'b0;
        mem_rdata = 8'h00;
        for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    end

    always @(negedge clk) begin
        if (clr) begin
            for (int i = 0; i < 16; i++) wr_cnt[i] = 0;
            total_req = 0; order_err = 0; gap_err = 0;
            done_cyc = 0; fail_cyc = 0; last_addr = -1;
            await_rd = 1'b0; gap = 0;
        end else begin
            if (done) done_cyc++;
            if (fail) fail_cyc++;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                total_req++;
                if (mem_we) begin
                    if (int'(mem_addr) < last_addr) order_err++;
                    last_addr = int'(mem_addr);
                    wr_cnt[mem_addr[3:0]]++;
                    if (int'(mem_addr) == bad_addr && bad_left > 0) begin
                        bad_left--;
                        mem[mem_addr[3:0]] = mem_wdata ^ 8'h01;
                    end else begin
                        mem[mem_addr[3:0]] = mem_wdata;
                    end
                    await_rd = 1'b1; gap = 0; wr_addr = int'(mem_addr);
                end else begin
                    mem_rdata <= mem[mem_addr[3:0]];
                    if (!await_rd || gap != SETTLE || int'(mem_addr) != wr_addr) gap_err++;
                    await_rd = 1'b0;
                end
            end else begin
                mem_ack <= 1'b0;
                if (await_rd && !mem_req) gap++;
            end
        end
    end

    function automatic logic [7:0] exp_byte(input logic [15:0] s, input int i);
        logic [7:0] c [10];
        logic [7:0] sum;
        c[0] = 8'h4E; c[1] = 8'h57; c[2] = 8'h59; c[3] = 8'h46;
        c[4] = 8'h00; c[5] = 8'h10; c[6] = 8'h57; c[7] = 8'hC0;
        c[8] = s[15:8]; c[9] = s[7:0];
        if (i < 10) return c[i];
        sum = 8'h55;
        for (int k = 0; k < 10; k++) sum = sum + c[k];
        return 8'h00 - sum;
    endfunction

    function automatic logic [47:0] exp_sta(input logic [15:0] s);
        return {exp_byte(s,4), exp_byte(s,5), exp_byte(s,6),
                exp_byte(s,7), exp_byte(s,8), exp_byte(s,9)};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // Pulse start, optionally a second start mid-run; wait for done or fail
    task automatic run(input logic [15:0] s, input bit restart, output bit got_done,
                       output logic [47:0] sta_at, output logic [7:0] code_at);
        int t;
        got_done = 1'b0; sta_at = '0; code_at = '0;
        @(negedge clk); serial = s; start = 1'b1;
        @(negedge clk); start = 1'b0; serial = ~s;
        check("R10 busy after start", busy, 1'b1);
        t = 0;
        while (!done && !fail && t < 30000) begin
            if (restart && t == 40) start = 1'b1;
            if (restart && t == 41) start = 1'b0;
            @(negedge clk); t++;
        end
        start = 1'b0;
        if (t >= 30000) check("R10 watchdog run end", 1'b0, 1'b1);
        got_done = done;
        sta_at = sta_addr; code_at = fail_code;
        check("R10 busy during pulse", busy, 1'b1);
        @(negedge clk);
        check("R10 single pulse", {done, fail}, 2'b00);
        check("R10 idle after pulse", busy, 1'b0);
    endtask

    task automatic t_reset();
        check("R12 busy", busy, 1'b0);
        check("R12 done", done, 1'b0);
        check("R12 fail", fail, 1'b0);
        check("R12 mem_req", mem_req, 1'b0);
        check("R12 sta_addr", sta_addr, 48'h0);
        check("R12 fail_code", fail_code, 8'h0);
    endtask

    task automatic t_clean(input logic [15:0] s);
        bit ok; logic [47:0] sa; logic [7:0] fc;
        clear_stats();
        run(s, 1'b0, ok, sa, fc);
        check("R9 done reached", ok, 1'b1);
        for (int i = 0; i < 8; i++) check("R1 fixed byte", mem[i], exp_byte(s, i));
        check("R2 serial high", mem[8], s[15:8]);
        check("R2 serial low", mem[9], s[7:0]);
        check("R3 checksum", mem[10], exp_byte(s, 10));
        check("R9 station value", sa, exp_sta(s));
        check("R4 ascending order", order_err, 0);
        check("R6 settle gap exact", gap_err, 0);
        for (int i = 0; i < 11; i++) check("R5 one write per byte", wr_cnt[i], 1);
        check("R10 done cycles", done_cyc, 1);
        check("R10 no fail", fail_cyc, 0);
    endtask

    task automatic t_rewrite_same(input logic [15:0] s);
        bit ok; logic [47:0] sa; logic [7:0] fc;
        clear_stats();
        run(s, 1'b0, ok, sa, fc);
        check("R5 done with preloaded memory", ok, 1'b1);
        for (int i = 0; i < 11; i++) check("R5 write despite match", wr_cnt[i], 1);
    endtask

    task automatic t_retry(input logic [15:0] s);
        bit ok; logic [47:0] sa; logic [7:0] fc;
        clear_stats();
        bad_addr = 3; bad_left = 5;
        run(s, 1'b0, ok, sa, fc);
        check("R7 done after retries", ok, 1'b1);
        check("R7 writes at bad address", wr_cnt[3], 6);
        check("R7 good byte in place", mem[3], 8'h46);
        check("R7 neighbour once", wr_cnt[4], 1);
        check("R6 settle gap with retries", gap_err, 0);
        bad_addr = -1;
    endtask

    task automatic t_fail(input logic [15:0] s, input logic [47:0] prev_sta);
        bit ok; logic [47:0] sa; logic [7:0] fc; int req_at;
        clear_stats();
        bad_addr = 7; bad_left = 1000;
        run(s, 1'b0, ok, sa, fc);
        req_at = total_req;
        check("R8 fail not done", ok, 1'b0);
        check("R8 fail_code", fc, 8'd8);
        check("R8 write limit", wr_cnt[7], TRIES);
        check("R8 later byte untouched", wr_cnt[8], 0);
        check("R8 station unchanged", sa, prev_sta);
        check("R10 fail cycles", fail_cyc, 1);
        check("R10 no done", done_cyc, 0);
        repeat (20) @(negedge clk);
        check("R8 no further requests", total_req, req_at);
        bad_addr = -1; bad_left = 0;
    endtask

    task automatic t_busy_start(input logic [15:0] s);
        bit ok; logic [47:0] sa; logic [7:0] fc;
        clear_stats();
        run(s, 1'b1, ok, sa, fc);
        check("R11 done", ok, 1'b1);
        check("R11 serial kept", sa, exp_sta(s));
        check("R11 checksum kept", mem[10], exp_byte(s, 10));
        for (int i = 0; i < 11; i++) check("R11 no extra writes", wr_cnt[i], 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        clear_stats();
        t_reset();
        t_clean(16'h1234);
        t_clean(16'hBEEF);
        t_rewrite_same(16'hBEEF);
        t_retry(16'h00A5);
        t_fail(16'h7F01, exp_sta(16'h00A5));
        t_busy_start(16'hC3C3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule